// File: doc/BRIEF.md
# Vertex Attribute Loader

This block assembles the input attributes of one vertex before shading. Given a vertex index, it walks the attribute slots in order. Each slot is either copied from a constant register or fetched from memory. A memory slot belongs to one of several vertex buffers. Each buffer holds a start offset, a per-vertex stride and a short list of 4-bit element codes. A code either names an entry in a shared table of element formats or asks for aligned padding. The block reads the element bytes through a byte-wide memory port. It widens each component to 32 bits and tags it as integer or float. It fills any missing lanes with defaults, then presents the finished attribute together with the shader input register picked from a permutation word.

A controller pulses `start` with all configuration inputs held steady. It then collects one result on each `outValid` cycle until `done` pulses. No float conversion takes place: integer lanes leave the block as sign- or zero-extended integers, and float lanes as raw IEEE single-precision patterns.

Top module: `vertex_attr_loader`

## Requirements
- R1: Slots are visited from 0 upward while the slot number is below `attrTotal`, which is capped at NUM_ATTR. When `fixedMask` bit s is set and slot s is reached between buffers, the block emits the 128-bit constant `fixedVals[128s+:128]` with all four float tags set, and reads no memory for that slot.
- R2: When buffer b is entered, its read pointer starts at `vertexBase + bufOffset[b] + vertexIndex * bufStride[b]`. Buffers are entered in order 0, 1, 2 and so on, one for each run of non-fixed slots.
- R3: Buffer b consumes `bufCompCnt[b]` codes from `bufCodes[64b+:64]`, lowest nibble first. Each non-padding code produces exactly one attribute, in the next slot. Once the codes are used up, the next buffer is taken.
- R4: A padding code (12 to 15) rounds the pointer up to a multiple of 4, then adds (code − 11) × 4. It produces no output.
- R5: A code c below 12 selects the format nibble `fmtWord[4c+:4]`. Bits 1:0 give the element type: 0 is a signed byte, 1 an unsigned byte, 2 a 16-bit signed short, 3 a 32-bit float. Bits 3:2 give the lane count minus one.
- R6: Elements are read little-endian, one byte per request. Data returns on `memData` one cycle after `memRd`. After an attribute, the pointer has advanced by the lane count times the element size (1, 1, 2 or 4).
- R7: Signed bytes and shorts are sign-extended to 32 bits, unsigned bytes are zero-extended, and floats pass unchanged. A fetched lane's `outIsFloat` bit is 1 only for the float type.
- R8: Lanes beyond the lane count read as 0 with the float tag set, except lane 3, which reads 32'h3F800000 with the float tag set. Lane i sits in `outData[32i+:32]`.
- R9: Each result carries its slot number on `outSlot`, and on `outReg` the nibble `permWord[4s+:4]` of that slot s.
- R10: After `start` the block is busy until a single-cycle `done`. `outValid` and `memRd` occur only while busy, never together.
- R11: The walk ends when the slot count is reached, even partway through a buffer's codes, or when all NUM_BUF buffers are used up. A run with `attrTotal` of 0 emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one vertex (taken when idle) |
| vertexIndex | input | IDX_W | Index of the vertex to load |
| vertexBase | input | 32 | Base byte address of all buffers |
| attrTotal | input | SLOT_W | Number of attribute slots |
| fixedMask | input | NUM_ATTR | Per-slot constant select |
| fixedVals | input | NUM_ATTR*128 | Per-slot constant, 4 lanes of 32 bits |
| bufOffset | input | NUM_BUF*32 | Per-buffer byte offset |
| bufStride | input | NUM_BUF*STRIDE_W | Per-buffer vertex stride in bytes |
| bufCompCnt | input | NUM_BUF*4 | Per-buffer number of codes |
| bufCodes | input | NUM_BUF*64 | Per-buffer list of 4-bit codes |
| fmtWord | input | 64 | Shared table of 4-bit format nibbles |
| permWord | input | NUM_ATTR*4 | Slot to shader input register map |
| memRd | output | 1 | Byte read request |
| memAddr | output | 32 | Byte read address |
| memData | input | 8 | Read data, one cycle after request |
| busy | output | 1 | Vertex in progress |
| done | output | 1 | One-cycle end-of-vertex pulse |
| outValid | output | 1 | Attribute result valid |
| outSlot | output | SLOT_W | Slot number of the result |
| outReg | output | 4 | Target shader input register |
| outData | output | 128 | Four 32-bit lanes, lane 0 lowest |
| outIsFloat | output | 4 | Per-lane float tag |

## Verification
Two things happen in the cycle the final byte of an element comes back from memory. The byte is merged into the element, and the merged value is widened and stored into its lane. Sign extension therefore depends on a byte that has not yet been registered. The bench fills memory with a pattern where many bytes have bit 7 set and uses signed byte and short formats, so the sign bit often arrives in that last byte. A scoreboard predicts every lane from the rules, and each emitted attribute is compared against it. A second overlap is tested by placing a padding code straight after an odd-sized read. The rounding must then act on a pointer that was advanced one cycle earlier.

// File: rtl/vertex_attr_loader_pkg.sv
package vertex_attr_loader_pkg;

  localparam logic [31:0] ONE_F32 = 32'h3F80_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NEXT, ST_CODE, ST_RD, ST_CAP, ST_EMIT, ST_DONE
  } vaState_t;

  typedef struct packed {
    logic bufLoad;
    logic padApply;
    logic attrClear;
    logic byteCapture;
    logic compStore;
    logic emitMem;
    logic emitFix;
  } vaCtrl_t;

endpackage

// File: rtl/vertex_attr_loader_ctrl.sv
module vertex_attr_loader_ctrl
  import vertex_attr_loader_pkg::*;
#(
  parameter int NUM_ATTR = 8,
  parameter int NUM_BUF  = 4,
  parameter int SLOT_W   = $clog2(NUM_ATTR + 1),
  parameter int BUF_W    = $clog2(NUM_BUF + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [SLOT_W-1:0]     attrTotal,
  input  logic [NUM_ATTR-1:0]   fixedMask,
  input  logic [NUM_BUF*4-1:0]  bufCompCnt,
  input  logic [NUM_BUF*64-1:0] bufCodes,
  input  logic [63:0]           fmtWord,
  output vaCtrl_t               ctl,
  output logic [BUF_W-1:0]      bufSel,
  output logic [SLOT_W-1:0]     attrSel,
  output logic [1:0]            elemType,
  output logic [1:0]            byteSel,
  output logic [1:0]            compSel,
  output logic [3:0]            padCode,
  output logic                  memRd,
  output logic                  busy,
  output logic                  done
);

  vaState_t state, stateN;
  logic [SLOT_W-1:0] attrIdx, attrLimit;
  logic [BUF_W-1:0]  bufIdx;
  logic [4:0]        codeIdx;
  logic [1:0]        compIdx, byteIdx, typeQ, cntM1Q, sizeM1;
  logic [63:0]       curCodes;
  logic [3:0]        curCnt, curCode, curFmt;
  logic              fixedHit;

  always_comb begin
    curCodes = '0;
    curCnt   = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (bufIdx == BUF_W'(b)) begin
        curCodes = bufCodes[b*64 +: 64];
        curCnt   = bufCompCnt[b*4 +: 4];
      end
    end
    fixedHit = 1'b0;
    for (int a = 0; a < NUM_ATTR; a++) begin
      if (attrIdx == SLOT_W'(a)) fixedHit = fixedMask[a];
    end
  end

  assign curCode   = curCodes[{codeIdx[3:0], 2'b00} +: 4];
  assign curFmt    = fmtWord[{curCode, 2'b00} +: 4];
  assign attrLimit = (attrTotal > SLOT_W'(NUM_ATTR)) ? SLOT_W'(NUM_ATTR) : attrTotal;

  always_comb begin
    case (typeQ)
      2'd2:    sizeM1 = 2'd1;
      2'd3:    sizeM1 = 2'd3;
      default: sizeM1 = 2'd0;
    endcase
  end

  always_comb begin
    stateN = state;
    ctl    = '0;
    memRd  = 1'b0;
    done   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) stateN = ST_NEXT;
      ST_NEXT: begin
        if (attrIdx >= attrLimit)              stateN = ST_DONE;
        else if (fixedHit)                     ctl.emitFix = 1'b1;
        else if (bufIdx >= BUF_W'(NUM_BUF))    stateN = ST_DONE;
        else begin
          ctl.bufLoad = 1'b1;
          stateN      = ST_CODE;
        end
      end
      ST_CODE: begin
        if (attrIdx >= attrLimit)              stateN = ST_DONE;
        else if (codeIdx >= {1'b0, curCnt})    stateN = ST_NEXT;
        else if (curCode >= 4'd12)             ctl.padApply = 1'b1;
        else begin
          ctl.attrClear = 1'b1;
          stateN        = ST_RD;
        end
      end
      ST_RD: begin
        memRd  = 1'b1;
        stateN = ST_CAP;
      end
      ST_CAP: begin
        ctl.byteCapture = 1'b1;
        if (byteIdx == sizeM1) begin
          ctl.compStore = 1'b1;
          stateN = (compIdx == cntM1Q) ? ST_EMIT : ST_RD;
        end else begin
          stateN = ST_RD;
        end
      end
      ST_EMIT: begin
        ctl.emitMem = 1'b1;
        stateN      = ST_CODE;
      end
      ST_DONE: begin
        done   = 1'b1;
        stateN = ST_IDLE;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      attrIdx <= '0;
      bufIdx  <= '0;
      codeIdx <= '0;
      compIdx <= '0;
      byteIdx <= '0;
      typeQ   <= '0;
      cntM1Q  <= '0;
    end else begin
      state <= stateN;
      case (state)
        ST_IDLE: if (start) begin
          attrIdx <= '0;
          bufIdx  <= '0;
        end
        ST_NEXT: begin
          if (ctl.emitFix)      attrIdx <= attrIdx + 1'b1;
          else if (ctl.bufLoad) codeIdx <= '0;
        end
        ST_CODE: begin
          if (stateN == ST_NEXT)  bufIdx  <= bufIdx + 1'b1;
          else if (ctl.padApply)  codeIdx <= codeIdx + 1'b1;
          else if (ctl.attrClear) begin
            typeQ   <= curFmt[1:0];
            cntM1Q  <= curFmt[3:2];
            compIdx <= '0;
            byteIdx <= '0;
          end
        end
        ST_CAP: begin
          if (ctl.compStore) begin
            byteIdx <= '0;
            compIdx <= compIdx + 1'b1;
          end else begin
            byteIdx <= byteIdx + 1'b1;
          end
        end
        ST_EMIT: begin
          attrIdx <= attrIdx + 1'b1;
          codeIdx <= codeIdx + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign bufSel   = bufIdx;
  assign attrSel  = attrIdx;
  assign elemType = typeQ;
  assign byteSel  = byteIdx;
  assign compSel  = compIdx;
  assign padCode  = curCode;
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/vertex_attr_loader_dp.sv
module vertex_attr_loader_dp
  import vertex_attr_loader_pkg::*;
#(
  parameter int NUM_ATTR = 8,
  parameter int NUM_BUF  = 4,
  parameter int IDX_W    = 16,
  parameter int STRIDE_W = 8,
  parameter int SLOT_W   = $clog2(NUM_ATTR + 1),
  parameter int BUF_W    = $clog2(NUM_BUF + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  vaCtrl_t                     ctl,
  input  logic [BUF_W-1:0]            bufSel,
  input  logic [SLOT_W-1:0]           attrSel,
  input  logic [1:0]                  elemType,
  input  logic [1:0]                  byteSel,
  input  logic [1:0]                  compSel,
  input  logic [3:0]                  padCode,
  input  logic [31:0]                 vertexBase,
  input  logic [IDX_W-1:0]            vertexIndex,
  input  logic [NUM_BUF*32-1:0]       bufOffset,
  input  logic [NUM_BUF*STRIDE_W-1:0] bufStride,
  input  logic [NUM_ATTR*128-1:0]     fixedVals,
  input  logic [NUM_ATTR*4-1:0]       permWord,
  input  logic [7:0]                  memData,
  output logic [31:0]                 memAddr,
  output logic                        outValid,
  output logic [SLOT_W-1:0]           outSlot,
  output logic [3:0]                  outReg,
  output logic [127:0]                outData,
  output logic [3:0]                  outIsFloat
);

  logic [31:0]         addr, selOff, elem, elemNext, extVal, padAdd;
  logic [STRIDE_W-1:0] selStride;
  logic [127:0]        selFixed;
  logic [3:0]          selPerm;
  logic [3:0][31:0]    compVal;
  logic [3:0]          compTag;

  always_comb begin
    selOff    = '0;
    selStride = '0;
    for (int b = 0; b < NUM_BUF; b++) begin
      if (bufSel == BUF_W'(b)) begin
        selOff    = bufOffset[b*32 +: 32];
        selStride = bufStride[b*STRIDE_W +: STRIDE_W];
      end
    end
    selFixed = '0;
    selPerm  = '0;
    for (int a = 0; a < NUM_ATTR; a++) begin
      if (attrSel == SLOT_W'(a)) begin
        selFixed = fixedVals[a*128 +: 128];
        selPerm  = permWord[a*4 +: 4];
      end
    end
    elemNext = elem;
    elemNext[{byteSel, 3'b000} +: 8] = memData;
    case (elemType)
      2'd0:    extVal = {{24{elemNext[7]}}, elemNext[7:0]};
      2'd1:    extVal = {24'd0, elemNext[7:0]};
      2'd2:    extVal = {{16{elemNext[15]}}, elemNext[15:0]};
      default: extVal = elemNext;
    endcase
  end

  assign padAdd  = {26'd0, padCode - 4'd11, 2'b00};
  assign memAddr = addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr       <= '0;
      elem       <= '0;
      compVal    <= '0;
      compTag    <= '0;
      outValid   <= 1'b0;
      outSlot    <= '0;
      outReg     <= '0;
      outData    <= '0;
      outIsFloat <= '0;
    end else begin
      if (ctl.bufLoad)
        addr <= vertexBase + selOff + 32'(vertexIndex) * 32'(selStride);
      else if (ctl.padApply)
        addr <= ((addr + 32'd3) & ~32'd3) + padAdd;
      else if (ctl.byteCapture)
        addr <= addr + 32'd1;

      if (ctl.byteCapture) elem <= elemNext;

      if (ctl.attrClear) begin
        compVal <= {ONE_F32, 32'd0, 32'd0, 32'd0};
        compTag <= 4'hF;
      end else if (ctl.compStore) begin
        compVal[compSel] <= extVal;
        compTag[compSel] <= (elemType == 2'd3);
      end

      outValid <= ctl.emitMem | ctl.emitFix;
      if (ctl.emitMem) begin
        outData    <= compVal;
        outIsFloat <= compTag;
        outSlot    <= attrSel;
        outReg     <= selPerm;
      end else if (ctl.emitFix) begin
        outData    <= selFixed;
        outIsFloat <= 4'hF;
        outSlot    <= attrSel;
        outReg     <= selPerm;
      end
    end
  end

endmodule

// File: rtl/vertex_attr_loader.sv
module vertex_attr_loader
  import vertex_attr_loader_pkg::*;
#(
  parameter int NUM_ATTR = 8,
  parameter int NUM_BUF  = 4,
  parameter int IDX_W    = 16,
  parameter int STRIDE_W = 8,
  parameter int SLOT_W   = $clog2(NUM_ATTR + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [IDX_W-1:0]            vertexIndex,
  input  logic [31:0]                 vertexBase,
  input  logic [SLOT_W-1:0]           attrTotal,
  input  logic [NUM_ATTR-1:0]         fixedMask,
  input  logic [NUM_ATTR*128-1:0]     fixedVals,
  input  logic [NUM_BUF*32-1:0]       bufOffset,
  input  logic [NUM_BUF*STRIDE_W-1:0] bufStride,
  input  logic [NUM_BUF*4-1:0]        bufCompCnt,
  input  logic [NUM_BUF*64-1:0]       bufCodes,
  input  logic [63:0]                 fmtWord,
  input  logic [NUM_ATTR*4-1:0]       permWord,
  output logic                        memRd,
  output logic [31:0]                 memAddr,
  input  logic [7:0]                  memData,
  output logic                        busy,
  output logic                        done,
  output logic                        outValid,
  output logic [SLOT_W-1:0]           outSlot,
  output logic [3:0]                  outReg,
  output logic [127:0]                outData,
  output logic [3:0]                  outIsFloat
);

  localparam int BUF_W = $clog2(NUM_BUF + 1);

  vaCtrl_t           ctl;
  logic [BUF_W-1:0]  bufSel;
  logic [SLOT_W-1:0] attrSel;
  logic [1:0]        elemType, byteSel, compSel;
  logic [3:0]        padCode;

  vertex_attr_loader_ctrl #(
    .NUM_ATTR(NUM_ATTR), .NUM_BUF(NUM_BUF), .SLOT_W(SLOT_W), .BUF_W(BUF_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .attrTotal(attrTotal),
    .fixedMask(fixedMask), .bufCompCnt(bufCompCnt), .bufCodes(bufCodes),
    .fmtWord(fmtWord), .ctl(ctl), .bufSel(bufSel), .attrSel(attrSel),
    .elemType(elemType), .byteSel(byteSel), .compSel(compSel),
    .padCode(padCode), .memRd(memRd), .busy(busy), .done(done)
  );

  vertex_attr_loader_dp #(
    .NUM_ATTR(NUM_ATTR), .NUM_BUF(NUM_BUF), .IDX_W(IDX_W),
    .STRIDE_W(STRIDE_W), .SLOT_W(SLOT_W), .BUF_W(BUF_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .bufSel(bufSel), .attrSel(attrSel),
    .elemType(elemType), .byteSel(byteSel), .compSel(compSel),
    .padCode(padCode), .vertexBase(vertexBase), .vertexIndex(vertexIndex),
    .bufOffset(bufOffset), .bufStride(bufStride), .fixedVals(fixedVals),
    .permWord(permWord), .memData(memData), .memAddr(memAddr),
    .outValid(outValid), .outSlot(outSlot), .outReg(outReg),
    .outData(outData), .outIsFloat(outIsFloat)
  );

endmodule

// File: rtl/vertex_attr_loader_chk.sv
module vertex_attr_loader_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              memRd,
  input logic              outValid,
  input logic [SLOT_W-1:0] outSlot,
  input logic [SLOT_W-1:0] attrTotal
);

  AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> busy); // R10

  AST_READ_IN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> busy); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R10

  AST_READ_NOT_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    memRd |-> !outValid); // R10

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outSlot < attrTotal)); // R11

endmodule

bind vertex_attr_loader vertex_attr_loader_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .memRd(memRd), .outValid(outValid), .outSlot(outSlot), .attrTotal(attrTotal)
);

// File: tb/vertex_attr_loader_tb.sv
module vertex_attr_loader_tb;

  localparam int NUM_ATTR = 8;
  localparam int NUM_BUF  = 4;
  localparam int IDX_W    = 16;
  localparam int STRIDE_W = 8;
  localparam int SLOT_W   = $clog2(NUM_ATTR + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IDX_W-1:0]            vertexIndex = '0;
  logic [31:0]                 vertexBase = '0;
  logic [SLOT_W-1:0]           attrTotal = '0;
  logic [NUM_ATTR-1:0]         fixedMask = '0;
  logic [NUM_ATTR*128-1:0]     fixedVals = '0;
  logic [NUM_BUF*32-1:0]       bufOffset = '0;
  logic [NUM_BUF*STRIDE_W-1:0] bufStride = '0;
  logic [NUM_BUF*4-1:0]        bufCompCnt = '0;
  logic [NUM_BUF*64-1:0]       bufCodes = '0;
  logic [63:0]                 fmtWord = '0;
  logic [NUM_ATTR*4-1:0]       permWord = '0;
  logic [7:0]                  memData = '0;
  logic                        memRd, busy, done, outValid;
  logic [31:0]                 memAddr;
  logic [SLOT_W-1:0]           outSlot;
  logic [3:0]                  outReg, outIsFloat;
  logic [127:0]                outData;

  logic [7:0]   mem [0:255];
  logic [139:0] expQ [$];
  int tests = 0, fails = 0, expCount = 0, gotCount = 0, cycles = 0;
  string reqTag = "R1";

  always #10 clk = ~clk;

  vertex_attr_loader #(
    .NUM_ATTR(NUM_ATTR), .NUM_BUF(NUM_BUF), .IDX_W(IDX_W), .STRIDE_W(STRIDE_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .vertexIndex(vertexIndex),
    .vertexBase(vertexBase), .attrTotal(attrTotal), .fixedMask(fixedMask),
    .fixedVals(fixedVals), .bufOffset(bufOffset), .bufStride(bufStride),
    .bufCompCnt(bufCompCnt), .bufCodes(bufCodes), .fmtWord(fmtWord),
    .permWord(permWord), .memRd(memRd), .memAddr(memAddr), .memData(memData),
    .busy(busy), .done(done), .outValid(outValid), .outSlot(outSlot),
    .outReg(outReg), .outData(outData), .outIsFloat(outIsFloat)
  );

  // memory model: one-cycle read latency (R6)
  always @(posedge clk) if (memRd) memData <= mem[memAddr[7:0]];

  task automatic check(input bit ok, input string req, input logic [139:0] act,
                       input logic [139:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      logic [139:0] act;
      logic [139:0] e;
      act = {outSlot, outReg, outIsFloat, outData};
      gotCount++;
      if (expQ.size() == 0) begin
        check(1'b0, {reqTag, " unexpected result"}, act, '0);
      end else begin
        e = expQ.pop_front();
        check(act == e, reqTag, act, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog R10 actual=%0d expected=done", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pushExp(input int slot, input logic [127:0] d, input logic [3:0] tg);
    expQ.push_back({SLOT_W'(slot), permWord[slot*4 +: 4], tg, d});
    expCount++;
  endtask

  // reference model built from the requirements
  task automatic modelVertex();
    int a = 0;
    int b = 0;
    int limit;
    logic [31:0] addr;
    limit = (int'(attrTotal) > NUM_ATTR) ? NUM_ATTR : int'(attrTotal);
    expCount = 0;
    while (a < limit) begin
      if (fixedMask[a]) begin
        pushExp(a, fixedVals[a*128 +: 128], 4'hF);
        a++;
      end else if (b >= NUM_BUF) begin
        break;
      end else begin
        addr = vertexBase + bufOffset[b*32 +: 32]
             + 32'(vertexIndex) * 32'(bufStride[b*STRIDE_W +: STRIDE_W]);
        for (int j = 0; j < int'(bufCompCnt[b*4 +: 4]) && a < limit; j++) begin
          int code;
          code = int'(bufCodes[b*64 + j*4 +: 4]);
          if (code >= 12) begin
            addr = ((addr + 32'd3) & ~32'd3) + 32'((code - 11) * 4);
          end else begin
            int f, t, n, sz;
            logic [3:0][31:0] v;
            logic [3:0] tg;
            f  = int'(fmtWord[code*4 +: 4]);
            t  = f & 3;
            n  = (f >> 2) + 1;
            sz = (t == 3) ? 4 : (t == 2) ? 2 : 1;
            v  = {32'h3F80_0000, 96'd0};
            tg = 4'hF;
            for (int c = 0; c < n; c++) begin
              logic [31:0] raw;
              raw = '0;
              for (int k = 0; k < sz; k++) raw[k*8 +: 8] = mem[8'(addr + 32'(k))];
              addr = addr + 32'(sz);
              case (t)
                0: v[c] = {{24{raw[7]}}, raw[7:0]};
                1: v[c] = {24'd0, raw[7:0]};
                2: v[c] = {{16{raw[15]}}, raw[15:0]};
                default: v[c] = raw;
              endcase
              tg[c] = (t == 3);
            end
            pushExp(a, v, tg);
            a++;
          end
        end
        b++;
      end
    end
  endtask

  task automatic runVertex(input string req);
    bit seen = 0;
    reqTag = req;
    gotCount = 0;
    modelVertex();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int w = 0; w < 5000; w++) begin
      if (done) begin
        seen = 1;
        break;
      end
      @(negedge clk);
    end
    check(seen, {req, " R10 done seen"}, 140'(seen), 140'd1);
    @(negedge clk);
    check(!done && !busy, {req, " R10 done one cycle"}, 140'({done, busy}), 140'd0);
    check(gotCount == expCount && expQ.size() == 0, {req, " R11 result count"},
          140'(gotCount), 140'(expCount));
    expQ.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 73 + 29) ^ (i >> 2));
    for (int a = 0; a < NUM_ATTR; a++)
      fixedVals[a*128 +: 128] = {32'(a*16+4), 32'(a*16+3), 32'(a*16+2), 32'(a*16+1)};
    // format nibbles: code0 float x3, code1 sbyte x4, code2 ubyte x2,
    // code3 short x1, code4 short x4, code5 float x1
    fmtWord  = 64'h0000_0000_003E_25CB;
    permWord = 32'h4C1F_82D6;
    repeat (3) @(negedge clk);
    check(!busy && !done && !outValid && !memRd, "R10 reset state",
          140'({busy, done, outValid, memRd}), 140'd0);
    rstN = 1'b1;
    @(negedge clk);

    // A: two buffers with padding, fixed slot between them
    vertexBase = 32'd16; vertexIndex = 16'd3; attrTotal = 4'd7; fixedMask = 8'h08;
    bufOffset  = {32'd0, 32'd0, 32'd40, 32'd8};
    bufStride  = {8'd0, 8'd0, 8'd20, 8'd12};
    bufCompCnt = {4'd0, 4'd0, 4'd4, 4'd4};
    bufCodes   = {64'd0, 64'd0, 64'h4E53, 64'h01D2};
    runVertex("R1/R2/R3/R4/R5/R6/R7/R8/R9 vertexA");

    // A again at index 0: aligned start
    vertexIndex = 16'd0;
    runVertex("R2/R4/R6/R7 vertexA0");

    // B: stop partway through a buffer
    vertexIndex = 16'd5; attrTotal = 4'd2; fixedMask = 8'h01;
    runVertex("R1/R11 vertexB");

    // C: buffers run out; padding-only buffer; unaligned pad
    vertexIndex = 16'd7; attrTotal = 4'd8; fixedMask = 8'h00;
    bufOffset  = {32'd100, 32'd0, 32'd60, 32'd8};
    bufStride  = {8'd3, 8'd0, 8'd5, 8'd9};
    bufCompCnt = {4'd2, 4'd0, 4'd1, 4'd1};
    bufCodes   = {64'h4C, 64'd0, 64'hC, 64'h5};
    runVertex("R3/R4/R11 vertexC");

    // D: all constants, count above cap
    attrTotal = 4'd15; fixedMask = 8'hFF;
    runVertex("R1/R9 vertexD");

    // E: zero slots
    attrTotal = 4'd0;
    runVertex("R11 vertexE");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule